// File: doc/BRIEF.md
# Preset Down-Counter Phase Timer

This block times a single phase of a pulse. A strobe on `start` copies a preset duration into an internal down-counter. From then on the counter steps down by one on each clock and comes to rest by itself at zero. While the counter holds a nonzero value the level output `phase_lvl` is high, so the high time equals the preset value times the clock period.

A pair of flip-flops watches `phase_lvl` and turns its falling edge into a `phase_done` strobe that lasts exactly one clock. The strobe can drive the `start` of another instance, so timers can be chained. For example, a high-phase timer can be linked to a low-phase timer, and the low-phase timer back to the first, to build a repeating waveform. The timer ignores a strobe that arrives while it is still counting. A preset of zero produces no activity at all.

Reset is asynchronous and active low. Its release is expected to come from a reset tree that is already synchronised to `clk`.

Top module: `dct_phase_timer`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `phase_lvl` and `phase_done` are both low.
- R2: When `start` is high at a rising edge E while the timer is idle (count zero), the count takes the value of `preset`. For a nonzero preset, `phase_lvl` is high in the cycle that follows E.
- R3: After a load at edge E with preset P > 0, `phase_lvl` is high after edges E through E+P-1 and low after edge E+P, which gives exactly P clocks high.
- R4: The count falls by exactly one per clock while nonzero, stops at zero with no outside action, and stays at zero (`phase_lvl` low) while `start` is low.
- R5: After a load at edge E with preset P > 0, `phase_done` is high only in the cycle between edges E+P+1 and E+P+2. It lasts exactly one clock and comes after the falling edge of `phase_lvl`.
- R6: A load of preset zero leaves `phase_lvl` low and produces no `phase_done` strobe.
- R7: A `start` strobe that arrives while the count is nonzero is ignored. Neither the new preset nor the strobe changes the timing of the phase in progress.
- R8: A `start` sampled at the edge that closes the `phase_done` cycle is accepted. Feeding the done strobe straight back as a start therefore runs phases back to back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Load strobe, active high, sampled on the rising edge |
| preset | input | CNT_W | Phase duration in clock cycles |
| phase_lvl | output | 1 | High while the count is nonzero |
| phase_done | output | 1 | One-clock strobe after `phase_lvl` falls |

## Verification
The bench builds the timer with `CNT_W = 4`. At that width every preset value from 0 to 15 can be swept. For each one, the level and the done strobe are compared cycle by cycle against windows computed from the preset. The small width also keeps busy-start injections, chained back-to-back phases and a reset in the middle of a phase short enough to cover in full. The zero and all-ones presets fall inside the sweep.

// File: rtl/dct_pkg.sv
package dct_pkg;

  localparam int unsigned DCT_DEF_CNT_W = 8;

  // A count register is idle when every bit is clear.
  function automatic logic dct_is_zero(input logic [63:0] v, input int unsigned w);
    logic z;
    z = 1'b1;
    for (int unsigned i = 0; i < 64; i++) begin
      if (i < w && v[i]) z = 1'b0;
    end
    return z;
  endfunction

endpackage

// File: rtl/dct_load_counter.sv
module dct_load_counter
  import dct_pkg::*;
#(
  parameter int unsigned CNT_W = DCT_DEF_CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [CNT_W-1:0] preset_i,
  output logic             busy_o
);

  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);
  localparam logic [CNT_W-1:0] CNT_ZERO = '0;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_idle;
  logic             load_en;
  logic             dec_en;
  logic             cnt_en;

  // Next-state logic
  always_comb begin
    cnt_idle = dct_is_zero(64'(cnt_q), CNT_W);
    load_en  = start_i && cnt_idle;
    dec_en   = !cnt_idle;
    cnt_en   = load_en || dec_en;
    if (load_en) begin
      cnt_d = preset_i;
    end else begin
      cnt_d = cnt_q - CNT_ONE;
    end
  end

  // Register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= CNT_ZERO;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign busy_o = !cnt_idle;

  // R2: an idle strobe loads the preset
  p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && cnt_q == CNT_ZERO) |=> (cnt_q == $past(preset_i)));

  // R7: a strobe while counting does not reload
  p_busy_ignore_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && cnt_q != CNT_ZERO) |=> (cnt_q == $past(cnt_q) - CNT_ONE));

  // R4: one step per clock while nonzero
  p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != CNT_ZERO) |=> (cnt_q == $past(cnt_q) - CNT_ONE));

  // R4: rest at zero without a strobe
  p_hold_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CNT_ZERO && !start_i) |=> (cnt_q == CNT_ZERO));

  // R6: zero preset leaves the timer idle
  p_zero_preset_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && cnt_q == CNT_ZERO && preset_i == CNT_ZERO) |=> !busy_o);

endmodule

// File: rtl/dct_fall_detect.sv
module dct_fall_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_i,
  output logic fall_o
);

  logic smp1_q, smp1_d;
  logic smp2_q, smp2_d;

  // Next-state logic
  always_comb begin
    smp1_d = lvl_i;
    smp2_d = smp1_q;
  end

  // Register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smp1_q <= 1'b0;
      smp2_q <= 1'b0;
    end else begin
      smp1_q <= smp1_d;
      smp2_q <= smp2_d;
    end
  end

  assign fall_o = smp2_q && !smp1_q;

  // R5: each falling edge yields a strobe in the next cycle
  p_fall_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lvl_i) |=> fall_o);

  // R5: strobe is one clock wide
  p_one_wide_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fall_o |=> !fall_o);

endmodule

// File: rtl/dct_phase_timer.sv
module dct_phase_timer
  import dct_pkg::*;
#(
  parameter int unsigned CNT_W = DCT_DEF_CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] preset,
  output logic             phase_lvl,
  output logic             phase_done
);

  logic busy;
  logic fall;

  dct_load_counter #(
    .CNT_W (CNT_W)
  ) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start),
    .preset_i (preset),
    .busy_o   (busy)
  );

  dct_fall_detect u_fall (
    .clk    (clk),
    .rst_n  (rst_n),
    .lvl_i  (busy),
    .fall_o (fall)
  );

  assign phase_lvl  = busy;
  assign phase_done = fall;

  // R5: done only after a high-to-low transition of the level
  p_done_after_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
    phase_done |-> (!$past(phase_lvl) && $past(phase_lvl, 2)));

  // R5: done never overlaps a still-high level that has not fallen
  p_done_low_lvl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    phase_done |-> !$past(phase_lvl));

endmodule

// File: tb/dct_phase_timer_bench.sv
module dct_phase_timer_bench;

  localparam int unsigned W = 4;
  localparam int unsigned PMAX = (1 << W) - 1;

  logic         clk;
  logic         rst_n;
  logic         start;
  logic [W-1:0] preset;
  logic         phase_lvl;
  logic         phase_done;

  int checks;
  int errors;
  bit finished;

  dct_phase_timer #(.CNT_W(W)) u_dct_phase_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .preset     (preset),
    .phase_lvl  (phase_lvl),
    .phase_done (phase_done)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%b expected=%b at %0t", req, what, act, exp, $time);
    end
  endtask

  // Strobe start at the current negedge; returns at the negedge after edge E (j=1).
  task automatic launch(input int p);
    start  = 1'b1;
    preset = W'(p);
    @(negedge clk);
    start  = 1'b0;
  endtask

  // Check cycles first..last after a load of preset p.
  task automatic observe(input int p, input int first, input int last);
    for (int j = first; j <= last; j++) begin
      if (j == 1) chk("R2", "lvl after load", phase_lvl, p > 0);
      else        chk("R3", "lvl window", phase_lvl, j <= p);
      if (p == 0) chk("R6", "no done for zero preset", phase_done, 1'b0);
      else        chk("R5", "done window", phase_done, j == p + 2);
      if (j < last) @(negedge clk);
    end
  endtask

  task automatic idle_check(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      chk("R4", "idle lvl", phase_lvl, 1'b0);
      chk("R4", "idle done", phase_done, 1'b0);
    end
  endtask

  initial begin
    checks = 0; errors = 0; finished = 0;
    rst_n = 1'b0; start = 1'b0; preset = '0;
    #5;
    chk("R1", "lvl in reset", phase_lvl, 1'b0);
    chk("R1", "done in reset", phase_done, 1'b0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "lvl after reset", phase_lvl, 1'b0);
    chk("R1", "done after reset", phase_done, 1'b0);

    // Full sweep of presets (R2, R3, R5, R6)
    for (int p = 0; p <= int'(PMAX); p++) begin
      launch(p);
      observe(p, 1, p + 4);
      idle_check(2);
    end

    // R7: busy start with a different preset is ignored
    @(negedge clk);
    launch(10);
    observe(10, 1, 2);
    start = 1'b1; preset = W'(2);
    @(negedge clk);
    start = 1'b0;
    observe(10, 3, 14);
    // R7: strobe held high through most of the phase
    @(negedge clk);
    launch(6);
    start = 1'b1; preset = W'(1);
    observe(6, 1, 5);
    start = 1'b0;
    @(negedge clk);
    observe(6, 6, 9);

    // R8: chained phases, start raised in the done cycle
    @(negedge clk);
    launch(3);
    observe(3, 1, 5);
    launch(5);
    observe(5, 1, 7);
    launch(1);
    observe(1, 1, 6);
    idle_check(3);

    // R1: reset in the middle of a phase
    launch(12);
    observe(12, 1, 4);
    rst_n = 1'b0;
    #1;
    chk("R1", "lvl on mid reset", phase_lvl, 1'b0);
    chk("R1", "done on mid reset", phase_done, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    idle_check(16);

    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule